// File: doc/BRIEF.md
# Walking-bit memory self-test controller

This block is a power-up self-test engine for a small synchronous single-port RAM. After a one-cycle start pulse it takes over the RAM port and fills every word with a background value. That value is all zeros in walking-one mode and all ones in walking-zero mode. It then moves a single inverted bit through the entire array, one bit position at a time. Around every move it scans the whole array, so it finds bits stuck at either level and bits that change when a neighbour is written.

Target bits are visited word by word from address zero upward, and inside a word from bit 0 upward. For each target the engine scans the array and expects pure background. It then inverts the target bit with a read-modify-write. It scans again and expects background everywhere except the target bit, which must read inverted. Finally it restores the target bit with a second read-modify-write. The first mismatching word stops the run. The engine records the address, the lowest mismatching bit position and the raw word that was read. It holds these until the next start.

Top module: `memtest_walk`

## Requirements
- R1: After reset, busy_o, done_o, fail_o and mem_en_o are all 0.
- R2: A start_i pulse while idle is accepted. From the next cycle busy_o is 1 and done_o and fail_o are 0. mode_i is captured at this point: 0 selects walking-one (background 0x00..0), 1 selects walking-zero (background all ones).
- R3: The first phase writes the background value to every word, in address order 0 to 2^AW-1.
- R4: Targets are visited by ascending address, then bit 0 to bit DW-1. For each target the engine writes the target word once with only the target bit inverted from background. It writes the word a second time restoring background. No other writes happen.
- R5: Each array scan reads every word in address order. Read data arrives one cycle after the request. The expected word is the background, except during the scan after the set write, when the target word expects its target bit inverted.
- R6: A pass with no mismatch keeps busy_o high for exactly 2^AW + 2^AW*DW*(2*2^AW+6) cycles.
- R7: A pass with no mismatch ends with done_o=1 and fail_o=0, and leaves every word holding the background value.
- R8: On the first mismatch the engine stops. From the next cycle done_o=1, fail_o=1, busy_o=0, and mem_en_o stays 0.
- R9: After a failure, fail_addr_o holds the mismatching word address and fail_bit_o holds the lowest bit index that differs from the expected word. fail_data_o holds the word as read. All three stay stable until the next accepted start.
- R10: A start_i pulse while busy_o is 1 has no effect on the running pass.
- R11: done_o stays 1 until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| mode_i | input | 1 | 0 = walking-one, 1 = walking-zero |
| mem_en_o | output | 1 | RAM access request |
| mem_we_o | output | 1 | RAM write enable (read when 0) |
| mem_addr_o | output | AW | RAM word address |
| mem_wdata_o | output | DW | RAM write data |
| mem_rdata_i | input | DW | RAM read data, valid one cycle after a read |
| busy_o | output | 1 | Test running |
| done_o | output | 1 | Test finished |
| fail_o | output | 1 | A mismatch was found |
| fail_addr_o | output | AW | Address of the failing word |
| fail_bit_o | output | $clog2(DW) | Lowest mismatching bit in that word |
| fail_data_o | output | DW | Data read from the failing word |

## Verification
A fault-free RAM is run in both modes. A scoreboard checks every write against the order and values predicted for the pass. This separates a correct walk from one that skips bits, visits them in the wrong order or writes more than one bit. Stuck-at-1 and stuck-at-0 cells are placed so that some are caught in the scan before the set write and others only in the scan after it. This tells the two scan expectations apart. Coupling faults, one inside the aggressor's word and one in a distant word, show that the post-set scan covers the whole array and that the lowest differing bit is reported.

// File: rtl/wbt_pkg.sv
package wbt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_INIT   = 3'd1,
        ST_CHECK  = 3'd2,
        ST_SET_RD = 3'd3,
        ST_SET_WR = 3'd4,
        ST_CLR_RD = 3'd5,
        ST_CLR_WR = 3'd6
    } wbt_state_e;
endpackage

// File: rtl/wbt_lowbit.sv
module wbt_lowbit #(
    parameter int DW = 8,
    parameter int BW = 3
) (
    input  logic [DW-1:0] vec_i,
    output logic [BW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = BW'(i);
        end
    end
endmodule

// File: rtl/wbt_expect.sv
module wbt_expect #(
    parameter int AW = 4,
    parameter int DW = 8,
    parameter int BW = 3
) (
    input  logic          mode_i,
    input  logic          flip_i,
    input  logic [AW-1:0] tgt_addr_i,
    input  logic [BW-1:0] tgt_bit_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] rdata_i,
    output logic [DW-1:0] expect_o,
    output logic          mismatch_o,
    output logic [BW-1:0] first_bit_o
);
    logic [DW-1:0] mask;
    logic [DW-1:0] diff;

    always_comb begin
        mask     = {{(DW-1){1'b0}}, 1'b1} << tgt_bit_i;
        expect_o = {DW{mode_i}};
        if (flip_i && (addr_i == tgt_addr_i)) expect_o = expect_o ^ mask;
        diff       = rdata_i ^ expect_o;
        mismatch_o = |diff;
    end

    wbt_lowbit #(.DW(DW), .BW(BW)) u_low (
        .vec_i (diff),
        .idx_o (first_bit_o)
    );
endmodule

// File: rtl/memtest_walk.sv
module memtest_walk
    import wbt_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8,
    localparam int BW = (DW > 1) ? $clog2(DW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    output logic          mem_en_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          fail_o,
    output logic [AW-1:0] fail_addr_o,
    output logic [BW-1:0] fail_bit_o,
    output logic [DW-1:0] fail_data_o
);
    localparam int DEPTH = 1 << AW;
    localparam int SCW   = AW + 1;

    typedef struct packed {
        wbt_state_e    st;
        logic          mode;
        logic          post;
        logic [AW-1:0] tgt_addr;
        logic [BW-1:0] tgt_bit;
        logic [SCW-1:0] scan;
        logic          rd_vld;
        logic [AW-1:0] rd_addr;
        logic          done;
        logic          fail;
        logic [AW-1:0] f_addr;
        logic [BW-1:0] f_bit;
        logic [DW-1:0] f_data;
    } regs_t;

    regs_t r_q, r_d;

    logic [DW-1:0] bg;
    logic [DW-1:0] tgt_mask;
    logic [DW-1:0] exp_word;
    logic          mismatch;
    logic [BW-1:0] first_bit;
    logic          last_tgt;

    wbt_expect #(.AW(AW), .DW(DW), .BW(BW)) u_exp (
        .mode_i      (r_q.mode),
        .flip_i      (r_q.post),
        .tgt_addr_i  (r_q.tgt_addr),
        .tgt_bit_i   (r_q.tgt_bit),
        .addr_i      (r_q.rd_addr),
        .rdata_i     (mem_rdata_i),
        .expect_o    (exp_word),
        .mismatch_o  (mismatch),
        .first_bit_o (first_bit)
    );

    always_comb begin
        bg       = {DW{r_q.mode}};
        tgt_mask = {{(DW-1){1'b0}}, 1'b1} << r_q.tgt_bit;
        last_tgt = (r_q.tgt_addr == {AW{1'b1}}) && (r_q.tgt_bit == BW'(DW - 1));

        r_d         = r_q;
        mem_en_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;

        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d          = '0;
                    r_d.st       = ST_INIT;
                    r_d.mode     = mode_i;
                end
            end
            ST_INIT: begin
                mem_en_o    = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.scan[AW-1:0];
                mem_wdata_o = bg;
                if (r_q.scan == SCW'(DEPTH - 1)) begin
                    r_d.st   = ST_CHECK;
                    r_d.scan = '0;
                end else begin
                    r_d.scan = r_q.scan + 1'b1;
                end
            end
            ST_CHECK: begin
                r_d.rd_vld = 1'b0;
                if (r_q.scan < SCW'(DEPTH)) begin
                    mem_en_o    = 1'b1;
                    mem_addr_o  = r_q.scan[AW-1:0];
                    r_d.rd_vld  = 1'b1;
                    r_d.rd_addr = r_q.scan[AW-1:0];
                    r_d.scan    = r_q.scan + 1'b1;
                end
                if (r_q.rd_vld && mismatch) begin
                    mem_en_o   = 1'b0;
                    r_d.rd_vld = 1'b0;
                    r_d.st     = ST_IDLE;
                    r_d.done   = 1'b1;
                    r_d.fail   = 1'b1;
                    r_d.f_addr = r_q.rd_addr;
                    r_d.f_bit  = first_bit;
                    r_d.f_data = mem_rdata_i;
                end else if (r_q.scan == SCW'(DEPTH)) begin
                    r_d.st   = r_q.post ? ST_CLR_RD : ST_SET_RD;
                    r_d.scan = '0;
                end
            end
            ST_SET_RD, ST_CLR_RD: begin
                mem_en_o   = 1'b1;
                mem_addr_o = r_q.tgt_addr;
                r_d.st     = (r_q.st == ST_SET_RD) ? ST_SET_WR : ST_CLR_WR;
            end
            ST_SET_WR: begin
                mem_en_o    = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.tgt_addr;
                mem_wdata_o = (mem_rdata_i & ~tgt_mask) | (~bg & tgt_mask);
                r_d.st      = ST_CHECK;
                r_d.post    = 1'b1;
                r_d.scan    = '0;
            end
            ST_CLR_WR: begin
                mem_en_o    = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.tgt_addr;
                mem_wdata_o = (mem_rdata_i & ~tgt_mask) | (bg & tgt_mask);
                r_d.post    = 1'b0;
                r_d.scan    = '0;
                if (last_tgt) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.st = ST_CHECK;
                    if (r_q.tgt_bit == BW'(DW - 1)) begin
                        r_d.tgt_bit  = '0;
                        r_d.tgt_addr = r_q.tgt_addr + 1'b1;
                    end else begin
                        r_d.tgt_bit = r_q.tgt_bit + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = r_q.done;
    assign fail_o      = r_q.fail;
    assign fail_addr_o = r_q.f_addr;
    assign fail_bit_o  = r_q.f_bit;
    assign fail_data_o = r_q.f_data;

    a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !done_o && !fail_o));

    a_r4_single_bit_rmw: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && (r_q.st == ST_SET_WR || r_q.st == ST_CLR_WR))
            |-> ($countones(mem_wdata_o ^ mem_rdata_i) <= 1));

    a_r8_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_en_o);

    a_r8_fail_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> done_o);

    a_r9_fail_record_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> (fail_o && $stable(fail_addr_o)
                                  && $stable(fail_bit_o) && $stable(fail_data_o)));

    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && r_q.st != ST_INIT) |=> (r_q.st != ST_INIT));

    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);
endmodule

// File: tb/memtest_walk_tb_top.sv
module memtest_walk_tb_top;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int BW    = 3;
    localparam int DEPTH = 1 << AW;
    localparam int PASS_CYC = DEPTH + DEPTH * DW * (2 * DEPTH + 6);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic          mem_en_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;
    logic [DW-1:0] mem_rdata_i;
    logic          busy_o, done_o, fail_o;
    logic [AW-1:0] fail_addr_o;
    logic [BW-1:0] fail_bit_o;
    logic [DW-1:0] fail_data_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    memtest_walk #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
        .fail_addr_o(fail_addr_o), .fail_bit_o(fail_bit_o), .fail_data_o(fail_data_o)
    );

    // RAM model with injectable faults
    logic [DW-1:0] mem [DEPTH];
    logic          stk_en = 1'b0, stk_val = 1'b0;
    logic [AW-1:0] stk_a = '0;
    int            stk_b = 0;
    logic          cpl_en = 1'b0;
    logic [AW-1:0] agg_a = '0, vic_a = '0;
    int            agg_b = 0, vic_b = 0;

    always @(posedge clk) begin
        if (mem_en_o) begin
            if (mem_we_o) begin
                mem[mem_addr_o] <= mem_wdata_o;
                if (cpl_en && mem_addr_o == agg_a && mem[agg_a][agg_b] != mem_wdata_o[agg_b])
                    mem[vic_a][vic_b] <= mem_wdata_o[agg_b];
            end else begin
                logic [DW-1:0] v;
                v = mem[mem_addr_o];
                if (stk_en && mem_addr_o == stk_a) v[stk_b] = stk_val;
                mem_rdata_i <= v;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard of expected RAM writes
    logic [AW+DW-1:0] exp_q[$];
    logic             sb_on = 1'b0;

    always @(negedge clk) begin
        if (sb_on && mem_en_o && mem_we_o) begin
            if (exp_q.size() == 0) begin
                chk("R4", {mem_addr_o, mem_wdata_o}, 32'hDEAD, "unexpected write");
            end else begin
                logic [AW+DW-1:0] e;
                e = exp_q.pop_front();
                chk("R4", {mem_addr_o, mem_wdata_o}, e, "write addr/data");
            end
        end
    end

    task automatic fill_mem();
        for (int a = 0; a < DEPTH; a++) mem[a] = 8'hA5;
    endtask

    task automatic push_expected(input logic mode);
        logic [DW-1:0] bg;
        bg = {DW{mode}};
        for (int a = 0; a < DEPTH; a++) exp_q.push_back({AW'(a), bg});            // R3 order
        for (int a = 0; a < DEPTH; a++)
            for (int b = 0; b < DW; b++) begin
                exp_q.push_back({AW'(a), bg ^ (DW'(1) << b)});                     // R4 set
                exp_q.push_back({AW'(a), bg});                                      // R4 restore
            end
    endtask

    task automatic pulse_start(input logic mode);
        @(negedge clk);
        mode_i  = mode;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2", {busy_o, done_o, fail_o}, 3'b100, "busy/done/fail after start");
    endtask

    task automatic run_clean(input logic mode);
        int cyc;
        fill_mem();
        exp_q.delete();
        push_expected(mode);
        sb_on = 1'b1;
        pulse_start(mode);
        cyc = 1;
        while (busy_o && cyc < 20000) begin
            @(negedge clk);
            if (cyc == 100) begin start_i = 1'b1; mode_i = ~mode; end      // R10 stray start
            if (cyc == 101) start_i = 1'b0;
            if (busy_o) cyc++;
        end
        sb_on = 1'b0;
        chk("R6", cyc, PASS_CYC, "busy cycles");
        chk("R7", {done_o, fail_o}, 2'b10, "done/fail after clean pass");
        chk("R10", exp_q.size(), 0, "writes left after stray start");
        for (int a = 0; a < DEPTH; a++)
            chk("R7", mem[a], {DW{mode}}, "final background");
        repeat (10) @(negedge clk);
        chk("R11", done_o, 1'b1, "done held");
        chk("R8", mem_en_o, 1'b0, "idle bus");
    endtask

    task automatic run_fail(input logic mode, input logic [AW-1:0] ea,
                            input int eb, input logic [DW-1:0] ed, input string tag);
        int cyc;
        fill_mem();
        pulse_start(mode);
        cyc = 0;
        while (busy_o && cyc < 20000) begin @(negedge clk); cyc++; end
        chk("R8", {busy_o, done_o, fail_o}, 3'b011, {tag, " status"});
        chk("R9", fail_addr_o, ea, {tag, " address"});
        chk("R9", fail_bit_o, eb, {tag, " bit"});
        chk("R9", fail_data_o, ed, {tag, " data"});
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_en_o) chk("R8", mem_en_o, 1'b0, {tag, " access after fail"});
        end
        chk("R9", {fail_addr_o, fail_bit_o, fail_data_o}, {ea, BW'(eb), ed}, {tag, " held"});
        chk("R11", done_o, 1'b1, {tag, " done held"});
        stk_en = 1'b0;
        cpl_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {busy_o, done_o, fail_o, mem_en_o}, 4'b0000, "in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {busy_o, done_o, fail_o, mem_en_o}, 4'b0000, "after reset");

        run_clean(1'b0);   // R3 R4 R5 walking-one
        run_clean(1'b1);   // walking-zero

        // R5: stuck-at-1, walking-one, seen in first scan
        stk_en = 1'b1; stk_a = 4'd5; stk_b = 3; stk_val = 1'b1;
        run_fail(1'b0, 4'd5, 3, 8'h08, "stuck1/w1");
        // R5: stuck-at-0, walking-one, seen only after set
        stk_en = 1'b1; stk_a = 4'd6; stk_b = 1; stk_val = 1'b0;
        run_fail(1'b0, 4'd6, 1, 8'h00, "stuck0/w1");
        stk_en = 1'b1; stk_a = 4'd2; stk_b = 6; stk_val = 1'b0;
        run_fail(1'b1, 4'd2, 6, 8'hBF, "stuck0/w0");
        stk_en = 1'b1; stk_a = 4'd12; stk_b = 4; stk_val = 1'b1;
        run_fail(1'b1, 4'd12, 4, 8'hFF, "stuck1/w0");
        // coupling inside one word: target bit set too, lowest differing bit is victim
        cpl_en = 1'b1; agg_a = 4'd3; agg_b = 2; vic_a = 4'd3; vic_b = 5;
        run_fail(1'b0, 4'd3, 5, 8'h24, "couple same word");
        // coupling into a distant word
        cpl_en = 1'b1; agg_a = 4'd1; agg_b = 0; vic_a = 4'd9; vic_b = 7;
        run_fail(1'b0, 4'd9, 7, 8'h80, "couple far word");

        // R2: a new start clears the failure and runs clean
        run_clean(1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule